// File: doc/BRIEF.md
# Evolutionary Search Iteration Controller

This block runs the outer loop of a steady-state genetic search. A search begins on a `start` pulse. In each iteration the controller picks three distinct parent indices at random and hands them to an external crossover unit. It then makes three mutation decisions, one for each offspring, and sends a request to an external mutation unit for each offspring that is chosen. Last, it asks an external insertion unit to merge the offspring into the population. The insertion unit returns the best fitness in the population; lower fitness is better.

A 16-bit LFSR supplies all random values. It advances only when a draw is made, so the random sequence does not depend on how long the datapath units take. The controller keeps the best fitness seen so far and counts completed iterations. It also counts how many iterations have passed without a strict improvement. The search ends when the iteration count reaches a fixed cap, or when the stagnation count reaches a window that software sets. When the search ends, `done` rises together with a reason code.

Each datapath unit uses a request/done handshake. The controller raises `*_start` and holds it, with its operands stable, until it samples the matching `*_done` high. The unit may take any number of cycles, so holding back `*_done` is its only means of back-pressure. A `*_done` pulse that arrives while the matching request is low has no effect.

Top module: `ga_iter_ctrl`

## Requirements
- R1: After reset, and until the first `start`, `busy`, `done`, `xo_start`, `mut_start` and `ins_start` are 0, `stop_code` is 00 and `iter_count` is 0.
- R2: The LFSR loads seed 16'hACE1 on reset. On each step it takes the next state {s[14:0], s[15]^s[14]^s[12]^s[3]}, which is the polynomial x^16+x^15+x^13+x^4+1. It steps once for every draw and at no other time, never holds zero, and is not reseeded by `start`.
- R3: A parent draw uses the low 8 bits of the current LFSR state. The draw is accepted only if it is below POP_SIZE (197) and differs from every parent already accepted in this iteration. A rejected draw still uses one step. The accepted values fill `par0`, `par1` and `par2` in that order and stay there during the crossover request.
- R4: Only one request is high at a time. The order is crossover, then any mutations, then insertion. Each request stays high until its done input is sampled high, and it is low in the cycle after.
- R5: After the crossover, the controller makes three draws for offspring slots 0, 1 and 2 in that order. A slot is mutated when the whole 16-bit LFSR state is below MUT_THRESH (default 655, about 1 percent). For each mutation, `mut_start` is raised with `mut_slot` set to the slot number. No mutation request is made for a slot that was not drawn.
- R6: `start` sets the best fitness to all ones. When an insertion completes with `ins_fit` strictly below the best fitness, the best fitness takes that value and the stagnation count clears to 0 on that same edge. An equal or higher value adds one to the count, which saturates at 2^14-1.
- R7: Each completed insertion adds 1 to `iter_count`. When the count reaches ITER_CAP (default 50000), the search stops with `stop_code` 01.
- R8: The 14-bit `stag_win` is sampled at `start`, so its largest value is 16383. The search stops with `stop_code` 10 when an iteration that does not improve brings the stagnation count to `stag_win` or above.
- R9: If the cap and the stagnation condition are met in the same iteration, `stop_code` is 01.
- R10: While `busy` is high, `start` is ignored. When the search stops, `busy` falls, and `done`, `stop_code` and `iter_count` keep their values until the next `start`. That `start` clears them and raises `busy` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search (ignored while busy) |
| stag_win | input | 14 | Stagnation window, sampled at start |
| busy | output | 1 | A search is running |
| done | output | 1 | The last search has ended |
| stop_code | output | 2 | 01 iteration cap, 10 stagnation, 00 none |
| iter_count | output | ITER_W | Iterations completed |
| par0 | output | IDX_W | First parent index |
| par1 | output | IDX_W | Second parent index |
| par2 | output | IDX_W | Third parent index |
| xo_start | output | 1 | Crossover request |
| xo_done | input | 1 | Crossover complete |
| mut_start | output | 1 | Mutation request |
| mut_slot | output | 2 | Offspring to mutate (0..2) |
| mut_done | input | 1 | Mutation complete |
| ins_start | output | 1 | Insertion request |
| ins_done | input | 1 | Insertion complete, `ins_fit` valid |
| ins_fit | input | FIT_W | Best population fitness after insertion |

## Verification
A wrong LFSR step or a faulty rejection rule shows at the next crossover request as wrong parent indices. The same fault also changes which mutation slots are requested in that iteration. Both appear within one iteration. A wrong stagnation or improvement rule moves the iteration at which `done` rises, or changes `stop_code`. A single wrong clear only shows once the window runs out, so the bench uses short windows and fitness patterns that are constant, strictly falling, or falling then flat, which make the stopping iteration exact.

// File: rtl/ga_ctrl_pkg.sv
package ga_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEL   = 3'd1,
    ST_XO    = 3'd2,
    ST_MDRAW = 3'd3,
    ST_MUT   = 3'd4,
    ST_INS   = 3'd5
  } ctrl_state_t;

  localparam logic [1:0] STOP_NONE = 2'b00;
  localparam logic [1:0] STOP_CAP  = 2'b01;
  localparam logic [1:0] STOP_STAG = 2'b10;

  localparam int RNG_W = 16;

  function automatic logic [RNG_W-1:0] rng_advance(input logic [RNG_W-1:0] s);
    return {s[RNG_W-2:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction

endpackage

// File: rtl/ga_lfsr16.sv
module ga_lfsr16
  import ga_ctrl_pkg::*;
#(
  parameter logic [RNG_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [RNG_W-1:0] state
);

  logic [RNG_W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (step) begin
      state_q <= rng_advance(state_q);
    end
  end

  assign state = state_q;

endmodule

// File: rtl/ga_parent_pick.sv
module ga_parent_pick #(
  parameter int POP_SIZE = 197,
  parameter int IDX_W    = 8,
  parameter int NPAR     = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       draw_en,
  input  logic [IDX_W-1:0]           cand,
  output logic [NPAR-1:0][IDX_W-1:0] par,
  output logic                       last_accept
);

  localparam int SLOT_W = $clog2(NPAR + 1);
  localparam logic [IDX_W:0] POP_LIM = (IDX_W + 1)'(POP_SIZE);

  logic [SLOT_W-1:0]          slot_q;
  logic [NPAR-1:0][IDX_W-1:0] par_q;
  logic [NPAR-1:0]            hit_vec;
  logic                       in_range;
  logic                       accept;

  // One comparator per held parent; only filled slots take part
  for (genvar k = 0; k < NPAR; k++) begin : g_dup
    assign hit_vec[k] = (SLOT_W'(k) < slot_q) && (par_q[k] == cand);
  end

  assign in_range    = {1'b0, cand} < POP_LIM;
  assign accept      = draw_en && in_range && (hit_vec == '0);
  assign last_accept = accept && (slot_q == SLOT_W'(NPAR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      par_q  <= '0;
    end else if (clear) begin
      slot_q <= '0;
    end else if (accept) begin
      par_q[slot_q] <= cand;
      slot_q        <= last_accept ? '0 : slot_q + 1'b1;
    end
  end

  assign par = par_q;

endmodule

// File: rtl/ga_stop_track.sv
module ga_stop_track
  import ga_ctrl_pkg::*;
#(
  parameter int ITER_CAP = 50000,
  parameter int ITER_W   = 16,
  parameter int STAG_W   = 14,
  parameter int FIT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [STAG_W-1:0] win_in,
  input  logic              upd,
  input  logic [FIT_W-1:0]  fit,
  output logic [ITER_W-1:0] iter,
  output logic [STAG_W-1:0] stag,
  output logic [FIT_W-1:0]  best,
  output logic              stop_hit,
  output logic [1:0]        stop_why
);

  localparam logic [STAG_W-1:0] STAG_MAX = '1;
  localparam logic [ITER_W-1:0] CAP_V    = ITER_W'(ITER_CAP);

  logic [ITER_W-1:0] iter_q, iter_nx;
  logic [STAG_W-1:0] stag_q, stag_nx, win_q;
  logic [FIT_W-1:0]  best_q;
  logic              improved, cap_hit, stag_hit;

  assign improved = fit < best_q;
  assign iter_nx  = iter_q + 1'b1;
  assign stag_nx  = improved ? '0 :
                    (stag_q == STAG_MAX) ? stag_q : stag_q + 1'b1;
  assign cap_hit  = iter_nx == CAP_V;
  assign stag_hit = !improved && (stag_nx >= win_q);
  assign stop_hit = upd && (cap_hit || stag_hit);
  assign stop_why = cap_hit ? STOP_CAP : STOP_STAG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iter_q <= '0;
      stag_q <= '0;
      best_q <= '1;
      win_q  <= '0;
    end else if (clear) begin
      iter_q <= '0;
      stag_q <= '0;
      best_q <= '1;
      win_q  <= win_in;
    end else if (upd) begin
      iter_q <= iter_nx;
      stag_q <= stag_nx;
      if (improved) best_q <= fit;
    end
  end

  assign iter = iter_q;
  assign stag = stag_q;
  assign best = best_q;

endmodule

// File: rtl/ga_iter_ctrl.sv
module ga_iter_ctrl
  import ga_ctrl_pkg::*;
#(
  parameter int               POP_SIZE   = 197,
  parameter int               ITER_CAP   = 50000,
  parameter int               STAG_W     = 14,
  parameter int               FIT_W      = 16,
  parameter int               MUT_THRESH = 655,
  parameter logic [RNG_W-1:0] LFSR_SEED  = 16'hACE1,
  localparam int              IDX_W      = $clog2(POP_SIZE),
  localparam int              ITER_W     = $clog2(ITER_CAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STAG_W-1:0] stag_win,
  output logic              busy,
  output logic              done,
  output logic [1:0]        stop_code,
  output logic [ITER_W-1:0] iter_count,
  output logic [IDX_W-1:0]  par0,
  output logic [IDX_W-1:0]  par1,
  output logic [IDX_W-1:0]  par2,
  output logic              xo_start,
  input  logic              xo_done,
  output logic              mut_start,
  output logic [1:0]        mut_slot,
  input  logic              mut_done,
  output logic              ins_start,
  input  logic              ins_done,
  input  logic [FIT_W-1:0]  ins_fit
);

  localparam int               NPAR     = 3;
  localparam logic [1:0]       LAST_OFF = 2'(NPAR - 1);
  localparam logic [RNG_W-1:0] MUT_LIM  = RNG_W'(MUT_THRESH);

  ctrl_state_t state_q, state_d;
  logic [1:0]  mslot_q, mslot_d;
  logic        done_q, done_d;
  logic [1:0]  code_q, code_d;

  logic [RNG_W-1:0]           lfsr_q;
  logic                       lfsr_step;
  logic                       mut_hit;
  logic                       go;
  logic                       pick_last;
  logic [NPAR-1:0][IDX_W-1:0] par_w;
  logic                       upd;
  logic [ITER_W-1:0]          iter_q;
  logic [STAG_W-1:0]          stag_q;
  logic [FIT_W-1:0]           best_q;
  logic                       stop_hit;
  logic [1:0]                 stop_why;

  assign go        = (state_q == ST_IDLE) && start;
  assign lfsr_step = (state_q == ST_SEL) || (state_q == ST_MDRAW);
  assign mut_hit   = lfsr_q < MUT_LIM;
  assign upd       = (state_q == ST_INS) && ins_done;

  ga_lfsr16 #(.SEED(LFSR_SEED)) u_rng (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (lfsr_step),
    .state (lfsr_q)
  );

  ga_parent_pick #(
    .POP_SIZE (POP_SIZE),
    .IDX_W    (IDX_W),
    .NPAR     (NPAR)
  ) u_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (go),
    .draw_en     (state_q == ST_SEL),
    .cand        (lfsr_q[IDX_W-1:0]),
    .par         (par_w),
    .last_accept (pick_last)
  );

  ga_stop_track #(
    .ITER_CAP (ITER_CAP),
    .ITER_W   (ITER_W),
    .STAG_W   (STAG_W),
    .FIT_W    (FIT_W)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (go),
    .win_in   (stag_win),
    .upd      (upd),
    .fit      (ins_fit),
    .iter     (iter_q),
    .stag     (stag_q),
    .best     (best_q),
    .stop_hit (stop_hit),
    .stop_why (stop_why)
  );

  always_comb begin
    state_d = state_q;
    mslot_d = mslot_q;
    done_d  = done_q;
    code_d  = code_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SEL;
          done_d  = 1'b0;
          code_d  = STOP_NONE;
        end
      end
      ST_SEL: begin
        if (pick_last) state_d = ST_XO;
      end
      ST_XO: begin
        if (xo_done) begin
          state_d = ST_MDRAW;
          mslot_d = '0;
        end
      end
      ST_MDRAW: begin
        if (mut_hit) begin
          state_d = ST_MUT;
        end else if (mslot_q == LAST_OFF) begin
          state_d = ST_INS;
        end else begin
          mslot_d = mslot_q + 1'b1;
        end
      end
      ST_MUT: begin
        if (mut_done) begin
          if (mslot_q == LAST_OFF) begin
            state_d = ST_INS;
          end else begin
            state_d = ST_MDRAW;
            mslot_d = mslot_q + 1'b1;
          end
        end
      end
      ST_INS: begin
        if (ins_done) begin
          if (stop_hit) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            code_d  = stop_why;
          end else begin
            state_d = ST_SEL;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mslot_q <= '0;
      done_q  <= 1'b0;
      code_q  <= STOP_NONE;
    end else begin
      state_q <= state_d;
      mslot_q <= mslot_d;
      done_q  <= done_d;
      code_q  <= code_d;
    end
  end

  assign busy       = state_q != ST_IDLE;
  assign done       = done_q;
  assign stop_code  = code_q;
  assign iter_count = iter_q;
  assign par0       = par_w[0];
  assign par1       = par_w[1];
  assign par2       = par_w[2];
  assign xo_start   = state_q == ST_XO;
  assign mut_start  = state_q == ST_MUT;
  assign mut_slot   = mslot_q;
  assign ins_start  = state_q == ST_INS;

endmodule

// File: rtl/ga_iter_ctrl_chk.sv
module ga_iter_ctrl_chk #(
  parameter int POP_SIZE = 197,
  parameter int ITER_CAP = 50000,
  parameter int STAG_W   = 14,
  parameter int FIT_W    = 16,
  parameter int IDX_W    = 8,
  parameter int ITER_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [1:0]        stop_code,
  input logic [ITER_W-1:0] iter_count,
  input logic [IDX_W-1:0]  par0,
  input logic [IDX_W-1:0]  par1,
  input logic [IDX_W-1:0]  par2,
  input logic              xo_start,
  input logic              xo_done,
  input logic              mut_start,
  input logic              ins_start,
  input logic              ins_done,
  input logic [FIT_W-1:0]  ins_fit,
  input logic [15:0]       lfsr_q,
  input logic [STAG_W-1:0] stag_q,
  input logic [FIT_W-1:0]  best_q
);

  localparam logic [STAG_W-1:0] STAG_MAX = '1;

  p_lfsr_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'd0);

  p_parents_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xo_start |-> ((IDX_W+1)'(par0) < (IDX_W+1)'(POP_SIZE)) &&
                 ((IDX_W+1)'(par1) < (IDX_W+1)'(POP_SIZE)) &&
                 ((IDX_W+1)'(par2) < (IDX_W+1)'(POP_SIZE)) &&
                 par0 != par1 && par0 != par2 && par1 != par2);

  p_one_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xo_start, mut_start, ins_start}));

  p_xo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xo_start && !xo_done |=> xo_start && $stable(par0) && $stable(par1) && $stable(par2));

  p_stag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ins_start && ins_done && (ins_fit < best_q) |=> stag_q == '0 && best_q == $past(ins_fit));

  p_stag_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ins_start && ins_done && !(ins_fit < best_q) && stag_q != STAG_MAX
      |=> stag_q == $past(stag_q) + 1'b1);

  p_iter_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ITER_W+1)'(iter_count) <= (ITER_W+1)'(ITER_CAP));

  p_code_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (stop_code == 2'b01 || stop_code == 2'b10));

  p_busy_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done && stop_code == 2'b00);

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !(ins_start && ins_done) |=> $stable(iter_count));

endmodule

bind ga_iter_ctrl ga_iter_ctrl_chk #(
  .POP_SIZE (POP_SIZE),
  .ITER_CAP (ITER_CAP),
  .STAG_W   (STAG_W),
  .FIT_W    (FIT_W),
  .IDX_W    (IDX_W),
  .ITER_W   (ITER_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .stop_code  (stop_code),
  .iter_count (iter_count),
  .par0       (par0),
  .par1       (par1),
  .par2       (par2),
  .xo_start   (xo_start),
  .xo_done    (xo_done),
  .mut_start  (mut_start),
  .ins_start  (ins_start),
  .ins_done   (ins_done),
  .ins_fit    (ins_fit),
  .lfsr_q     (lfsr_q),
  .stag_q     (stag_q),
  .best_q     (best_q)
);

// File: tb/ga_iter_ctrl_tb.sv
module ga_iter_ctrl_tb;

  localparam int CLK_P  = 10;
  localparam int CAP    = 40;
  localparam int MUT_TH = 2000;
  localparam int POP    = 197;
  localparam int IW     = $clog2(CAP + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [13:0] stag_win = '0;
  logic        busy, done;
  logic [1:0]  stop_code;
  logic [IW-1:0] iter_count;
  logic [7:0]  par0, par1, par2;
  logic        xo_start, mut_start, ins_start;
  logic        xo_done = 1'b0, mut_done = 1'b0, ins_done = 1'b0;
  logic [1:0]  mut_slot;
  logic [15:0] ins_fit = '0;

  int total = 0;
  int bad   = 0;
  logic [15:0] m_lfsr = 16'hACE1;

  always #(CLK_P/2) clk = ~clk;

  ga_iter_ctrl #(.POP_SIZE(POP), .ITER_CAP(CAP), .MUT_THRESH(MUT_TH)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stag_win(stag_win),
    .busy(busy), .done(done), .stop_code(stop_code), .iter_count(iter_count),
    .par0(par0), .par1(par1), .par2(par2),
    .xo_start(xo_start), .xo_done(xo_done),
    .mut_start(mut_start), .mut_slot(mut_slot), .mut_done(mut_done),
    .ins_start(ins_start), .ins_done(ins_done), .ins_fit(ins_fit)
  );

  function automatic logic [15:0] nx(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // mode 0 random, 1 strictly falling, 2 falling to iteration 30 then flat, 3 constant
  function automatic logic [15:0] pick_fit(input int mode, input int k, input logic [15:0] best);
    int r;
    case (mode)
      1: return 16'(1000 - k);
      2: return (k <= 30) ? 16'(1000 - k) : 16'd970;
      3: return 16'd500;
      default: begin
        r = $urandom_range(0, 9);
        if (best == 16'hFFFF) return 16'd5000;
        if (r < 3 && best > 16'd4) return best - 16'(1 + $urandom_range(0, 2));
        if (r < 6) return best;
        return best + 16'd1;
      end
    endcase
  endfunction

  task automatic run_search(input logic [13:0] win, input int mode, input int mid_start,
                            input int exp_code, input int exp_iter);
    logic [15:0] m_best;
    int m_stag, m_iter, d;
    bit stop, improved, cap, sh;
    logic [7:0] ep [3];
    stag_win = win;
    pulse_start();
    chk("R10 busy after start", busy, 1);
    chk("R10 done cleared by start", done, 0);
    chk("R10 count cleared by start", iter_count, 0);
    m_best = 16'hFFFF; m_stag = 0; m_iter = 0; stop = 0;
    while (!stop) begin
      // expected parents from the LFSR model with rejection
      for (int n = 0; n < 3; ) begin
        logic [7:0] c;
        bit dup;
        c = m_lfsr[7:0];
        dup = 0;
        for (int j = 0; j < n; j++) if (ep[j] == c) dup = 1;
        if (c < POP && !dup) begin ep[n] = c; n++; end
        m_lfsr = nx(m_lfsr);
      end
      while (!xo_start) @(negedge clk);
      chk("R2 R3 parent 0", par0, ep[0]);
      chk("R2 R3 parent 1", par1, ep[1]);
      chk("R2 R3 parent 2", par2, ep[2]);
      d = $urandom_range(0, 2);
      for (int w = 0; w < d; w++) begin
        @(negedge clk);
        chk("R4 crossover request held", xo_start, 1);
      end
      xo_done = 1'b1;
      @(negedge clk);
      xo_done = 1'b0;
      chk("R4 crossover request dropped", xo_start, 0);
      for (int s = 0; s < 3; s++) begin
        bit hit;
        hit = m_lfsr < 16'(MUT_TH);
        m_lfsr = nx(m_lfsr);
        if (hit) begin
          while (!(mut_start || ins_start)) @(negedge clk);
          chk("R5 mutation requested", mut_start, 1);
          chk("R5 mutation slot", mut_slot, s);
          mut_done = 1'b1;
          @(negedge clk);
          mut_done = 1'b0;
        end
      end
      while (!(mut_start || ins_start)) @(negedge clk);
      chk("R5 no extra mutation", mut_start, 0);
      chk("R4 insertion after mutations", ins_start, 1);
      ins_fit = pick_fit(mode, m_iter + 1, m_best);
      improved = ins_fit < m_best;
      if (improved) begin m_best = ins_fit; m_stag = 0; end
      else m_stag = m_stag + 1;
      m_iter++;
      cap = (m_iter == CAP);
      sh  = !improved && (m_stag >= win);
      ins_done = 1'b1;
      @(negedge clk);
      ins_done = 1'b0;
      chk("R7 iteration count", iter_count, m_iter);
      if (cap || sh) begin
        stop = 1;
        chk("R8 R9 done raised", done, 1);
        chk("R10 busy dropped", busy, 0);
        chk("R7 R8 R9 stop code", stop_code, cap ? 1 : 2);
      end else begin
        chk("R6 R8 still running", busy, 1);
        if (m_iter == mid_start) begin
          pulse_start();
          chk("R10 start while busy ignored", iter_count, m_iter);
          chk("R10 busy kept", busy, 1);
        end
      end
    end
    if (exp_code != 0) chk("R7 R8 R9 directed stop code", stop_code, exp_code);
    if (exp_iter != 0) chk("R6 R7 R8 directed stop iteration", iter_count, exp_iter);
    repeat (3) @(negedge clk);
    chk("R10 done held", done, 1);
    chk("R10 count held", iter_count, m_iter);
    chk("R4 no request after stop", {xo_start, mut_start, ins_start}, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", busy, 0);
    chk("R1 done at reset", done, 0);
    chk("R1 code at reset", stop_code, 0);
    chk("R1 count at reset", iter_count, 0);
    chk("R1 requests at reset", {xo_start, mut_start, ins_start}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle before start", busy, 0);
    run_search(14'd5,     0, 2, 0, 0);
    run_search(14'd16383, 1, 0, 1, CAP);
    run_search(14'd10,    2, 0, 1, CAP);
    run_search(14'd3,     3, 0, 2, 4);
    run_search(14'd8,     0, 3, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule